// File: doc/BRIEF.md
# Multiframe Sequence Reassembly Placement Engine

This block decides where each arriving frame of a multiframe sequence lands in a pool of equal-sized host buffers. It takes one frame event at a time (sequence count, last-frame flag, payload byte count) and draws buffer addresses from a free-buffer supply. For every frame it issues write commands to a separate data mover. A write command says whether to store the frame's header structure or a slice of its payload, and gives the buffer address, the byte offset inside that buffer and the byte count. The data mover does the actual copying.

While the frames arrive in order, the payloads are packed back to back across the buffers. A gap in the sequence count closes the current in-order portion. The block reports that portion in a completion message that raises no interrupt, then opens a new portion made of a header buffer followed by data buffers. The final frame closes the sequence with a completion message and a one-cycle interrupt request. From the headers and the completion messages, the host can put a sequence that arrived out of order back together. Only one sequence is reassembled at a time.

Top module: `mfs_reassembler`

## Requirements
- R1: After reset `frm_ready_o` is 1 and `wr_valid_o`, `cmp_valid_o`, `irq_o` and `fb_take_o` are 0.
- R2: A frame that arrives while no sequence is open starts a new sequence. It takes one buffer and issues a header write (`wr_hdr_o`=1, offset 0, length `HDR_BYTES`) there. Its payload starts at offset 0 of the next buffer taken.
- R3: A frame whose count equals the previous frame's count plus one, modulo 2^`SEQ_W`, is in order. It produces no header write, and its payload is appended at the current fill offset of the current data buffer.
- R4: A payload slice never crosses a buffer end. When the current buffer is full, or would overflow, the block writes up to its end and places the rest at offset 0 of freshly taken buffers, so a payload may produce several writes.
- R5: An out-of-order frame first emits a completion with `cmp_final_o`=0 and `irq_o`=0. That completion reports the portion's frame count, its payload byte total and the last buffer written, and it comes before any write for the new frame.
- R6: After a break in order, the frame's header goes to a newly taken buffer and its payload to the next newly taken buffer, even if the old data buffer still had room. The frames that follow in order pack as in R3.
- R7: After the last payload write of a frame flagged last, the block emits a completion with `cmp_final_o`=1 and pulses `irq_o` in the same cycle. The sequence is then closed, so the next frame starts a new sequence per R2 whatever its count.
- R8: `fb_take_o` is asserted only while `fb_valid_i` is 1. When a buffer is needed and the supply is empty, the block waits with no writes and keeps `frm_ready_o` low.
- R9: One frame is handled at a time: `frm_ready_o` is 0 from the cycle after a frame is accepted until that frame is fully placed.
- R10: A zero-length payload produces no payload write and takes no buffer.
- R11: Every write satisfies offset + length <= `buf_bytes_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_bytes_i | input | LEN_W | Host buffer size in bytes (>= HDR_BYTES, stable during a sequence) |
| frm_valid_i | input | 1 | Frame event present |
| frm_ready_o | output | 1 | Frame event accepted when high with valid |
| frm_seq_i | input | SEQ_W | Sequence count of the frame |
| frm_last_i | input | 1 | Frame is the final one of its sequence |
| frm_len_i | input | LEN_W | Payload bytes of the frame |
| fb_valid_i | input | 1 | Free buffer address available |
| fb_addr_i | input | ADDR_W | Address of the offered free buffer |
| fb_take_o | output | 1 | Offered buffer is consumed this cycle |
| wr_valid_o | output | 1 | Write command valid |
| wr_hdr_o | output | 1 | 1: header structure, 0: payload slice |
| wr_addr_o | output | ADDR_W | Buffer address of the write |
| wr_off_o | output | LEN_W | Byte offset inside the buffer |
| wr_len_o | output | LEN_W | Bytes to write |
| cmp_valid_o | output | 1 | Completion message valid |
| cmp_final_o | output | 1 | Completion closes the whole sequence |
| cmp_frames_o | output | SEQ_W | Frames in the reported portion |
| cmp_bytes_o | output | LEN_W+SEQ_W | Payload bytes in the reported portion |
| cmp_buf_o | output | ADDR_W | Last buffer written in the portion |
| irq_o | output | 1 | Host interrupt request, one cycle |

## Verification
The placement logic is driven with a purely in-order run, a run with a single gap, a wrap of the count from its maximum value to zero, and a payload that exactly fills a buffer followed by a zero-length frame. It is also driven with a payload several buffers long and with an empty buffer supply. The in-order run shows whether payload slices are appended at the right offset and split at the buffer end. The gap run shows whether the quiet completion comes first and whether fresh header and data buffers are taken, rather than the old data buffer being reused. The wrap case tells a correct modulo comparison from a plain one. The exact-fill, zero-length and long-payload cases exercise the boundary arithmetic. The empty-supply case shows that the engine waits instead of consuming buffers that are not there.

// File: rtl/mfs_reassembler.sv
module mfs_reassembler #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int SEQ_W     = 16,
  parameter int HDR_BYTES = 32,
  localparam int TOT_W    = LEN_W + SEQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  buf_bytes_i,
  input  logic              frm_valid_i,
  output logic              frm_ready_o,
  input  logic [SEQ_W-1:0]  frm_seq_i,
  input  logic              frm_last_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  logic              fb_valid_i,
  input  logic [ADDR_W-1:0] fb_addr_i,
  output logic              fb_take_o,
  output logic              wr_valid_o,
  output logic              wr_hdr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LEN_W-1:0]  wr_off_o,
  output logic [LEN_W-1:0]  wr_len_o,
  output logic              cmp_valid_o,
  output logic              cmp_final_o,
  output logic [SEQ_W-1:0]  cmp_frames_o,
  output logic [TOT_W-1:0]  cmp_bytes_o,
  output logic [ADDR_W-1:0] cmp_buf_o,
  output logic              irq_o
);

  typedef enum logic [2:0] {S_IDLE, S_CLOSE, S_HDR, S_DATA, S_FIN} state_t;

  state_t            state;
  logic              active, last_q, cur_valid;
  logic [SEQ_W-1:0]  exp_seq, pfrm;
  logic [LEN_W-1:0]  rem, fill;
  logic [TOT_W-1:0]  pbytes;
  logic [ADDR_W-1:0] cur_addr, last_buf;

  logic             accept, need_buf, data_go, hdr_go, fresh;
  logic [LEN_W-1:0] room, chunk;

  assign accept   = frm_valid_i && frm_ready_o;
  assign need_buf = !cur_valid || (fill >= buf_bytes_i);
  assign room     = need_buf ? buf_bytes_i : buf_bytes_i - fill;
  assign chunk    = (rem < room) ? rem : room;
  assign hdr_go   = (state == S_HDR) && fb_valid_i;
  assign data_go  = (state == S_DATA) && (rem != '0) && (!need_buf || fb_valid_i);
  assign fresh    = (state == S_HDR) || need_buf;

  assign frm_ready_o  = (state == S_IDLE);
  assign fb_take_o    = hdr_go || (data_go && need_buf);
  assign wr_valid_o   = hdr_go || data_go;
  assign wr_hdr_o     = (state == S_HDR);
  assign wr_addr_o    = fresh ? fb_addr_i : cur_addr;
  assign wr_off_o     = fresh ? '0 : fill;
  assign wr_len_o     = (state == S_HDR) ? LEN_W'(HDR_BYTES) : chunk;
  assign cmp_valid_o  = (state == S_CLOSE) || (state == S_FIN);
  assign cmp_final_o  = (state == S_FIN);
  assign irq_o        = (state == S_FIN);
  assign cmp_frames_o = pfrm;
  assign cmp_bytes_o  = pbytes;
  assign cmp_buf_o    = last_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      active    <= 1'b0;
      last_q    <= 1'b0;
      cur_valid <= 1'b0;
      exp_seq   <= '0;
      pfrm      <= '0;
      rem       <= '0;
      fill      <= '0;
      pbytes    <= '0;
      cur_addr  <= '0;
      last_buf  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          last_q  <= frm_last_i;
          rem     <= frm_len_i;
          exp_seq <= frm_seq_i + 1'b1;
          if (!active) begin
            active <= 1'b1;
            pfrm   <= 1;
            pbytes <= TOT_W'(frm_len_i);
            state  <= S_HDR;
          end else if (frm_seq_i == exp_seq) begin
            pfrm   <= pfrm + 1'b1;
            pbytes <= pbytes + TOT_W'(frm_len_i);
            state  <= S_DATA;
          end else begin
            state  <= S_CLOSE;
          end
        end
        S_CLOSE: begin
          pfrm   <= 1;
          pbytes <= TOT_W'(rem);
          state  <= S_HDR;
        end
        S_HDR: if (fb_valid_i) begin
          last_buf  <= fb_addr_i;
          cur_valid <= 1'b0;
          state     <= S_DATA;
        end
        S_DATA: begin
          if (rem == '0) begin
            state <= last_q ? S_FIN : S_IDLE;
          end else if (data_go) begin
            rem  <= rem - chunk;
            fill <= wr_off_o + chunk;
            if (need_buf) begin
              cur_addr  <= fb_addr_i;
              cur_valid <= 1'b1;
              last_buf  <= fb_addr_i;
            end
          end
        end
        S_FIN: begin
          active <= 1'b0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mfs_reassembler_chk.sv
module mfs_reassembler_chk #(
  parameter int LEN_W     = 16,
  parameter int HDR_BYTES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] buf_bytes_i,
  input logic             frm_valid_i,
  input logic             frm_ready_o,
  input logic             fb_valid_i,
  input logic             fb_take_o,
  input logic             wr_valid_o,
  input logic             wr_hdr_o,
  input logic [LEN_W-1:0] wr_off_o,
  input logic [LEN_W-1:0] wr_len_o,
  input logic             cmp_valid_o,
  input logic             cmp_final_o,
  input logic             irq_o
);

  // R8
  take_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_take_o |-> fb_valid_i);

  // R11
  wr_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> ({1'b0, wr_off_o} + {1'b0, wr_len_o} <= {1'b0, buf_bytes_i}));

  // R7
  irq_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cmp_valid_o && cmp_final_o));

  // R5
  close_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_o && !cmp_final_o) |-> !irq_o);

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid_o, cmp_valid_o}));

  // R9
  one_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && frm_ready_o) |=> !frm_ready_o);

  // R2
  hdr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_hdr_o) |-> (wr_off_o == '0 && wr_len_o == LEN_W'(HDR_BYTES)));

endmodule

bind mfs_reassembler mfs_reassembler_chk #(.LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES)) u_chk (.*);

// File: tb/mfs_reassembler_test.sv
`timescale 1ns/1ps
module mfs_reassembler_test;
  localparam int AW = 32, LW = 16, SW = 16;

  logic clk = 0, rst_n = 0;
  logic [LW-1:0] buf_bytes = 64;
  logic frm_valid = 0, frm_last = 0, fb_valid = 1;
  logic [SW-1:0] frm_seq = 0;
  logic [LW-1:0] frm_len = 0;
  logic frm_ready, fb_take, wr_valid, wr_hdr, cmp_valid, cmp_final, irq;
  logic [AW-1:0] fb_addr, wr_addr, cmp_buf;
  logic [LW-1:0] wr_off, wr_len;
  logic [SW-1:0] cmp_frames;
  logic [LW+SW-1:0] cmp_bytes;
  logic [AW-1:0] next_buf = 32'h1000;

  int errors = 0, checks = 0, cyc = 0, takes = 0, stray_irq = 0;
  int ev_n = 0;
  int ev_k [0:63];
  logic [AW-1:0] ev_a [0:63];
  int ev_o [0:63];
  int ev_l [0:63];
  bit ev_i [0:63];

  always #2.5 clk = ~clk;

  mfs_reassembler uut (
    .clk(clk), .rst_n(rst_n), .buf_bytes_i(buf_bytes),
    .frm_valid_i(frm_valid), .frm_ready_o(frm_ready), .frm_seq_i(frm_seq),
    .frm_last_i(frm_last), .frm_len_i(frm_len),
    .fb_valid_i(fb_valid), .fb_addr_i(fb_addr), .fb_take_o(fb_take),
    .wr_valid_o(wr_valid), .wr_hdr_o(wr_hdr), .wr_addr_o(wr_addr),
    .wr_off_o(wr_off), .wr_len_o(wr_len),
    .cmp_valid_o(cmp_valid), .cmp_final_o(cmp_final), .cmp_frames_o(cmp_frames),
    .cmp_bytes_o(cmp_bytes), .cmp_buf_o(cmp_buf), .irq_o(irq));

  assign fb_addr = next_buf;
  always @(posedge clk) if (fb_take) next_buf <= next_buf + 32'h100;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (fb_take) takes++;
    if (irq && !cmp_valid) stray_irq++;
    if (ev_n < 64 && wr_valid) begin
      ev_k[ev_n] = wr_hdr ? 0 : 1; ev_a[ev_n] = wr_addr;
      ev_o[ev_n] = int'(wr_off); ev_l[ev_n] = int'(wr_len); ev_i[ev_n] = irq; ev_n++;
    end else if (ev_n < 64 && cmp_valid) begin
      ev_k[ev_n] = cmp_final ? 3 : 2; ev_a[ev_n] = cmp_buf;
      ev_o[ev_n] = int'(cmp_frames); ev_l[ev_n] = int'(cmp_bytes); ev_i[ev_n] = irq; ev_n++;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kind: 0 header write, 1 payload write, 2 closing completion, 3 final completion
  // for completions: a = last buffer, o = frames, l = bytes
  task automatic chk_ev(int i, int k, logic [AW-1:0] a, int o, int l, string tag);
    if (i >= ev_n) begin check({tag, " missing event"}, i, ev_n); return; end
    check({tag, " kind"}, ev_k[i], k);
    check({tag, " addr/off/len"}, {ev_a[i], 16'(ev_o[i]), 16'(ev_l[i])},
          {a, 16'(o), 16'(l)});
    check({tag, " irq"}, ev_i[i], (k == 3));
  endtask

  task automatic send(int seq, int len, bit last);
    frm_valid = 1; frm_seq = SW'(seq); frm_len = LW'(len); frm_last = last;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!frm_ready && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ready", frm_ready, 1);
    check("R1 wr_valid", wr_valid, 0);
    check("R1 cmp_valid", cmp_valid, 0);
    check("R1 irq", irq, 0);
    check("R1 fb_take", fb_take, 0);
  endtask

  task automatic t_in_order();
    logic [AW-1:0] b = next_buf;
    ev_n = 0;
    send(5, 40, 0); send(6, 40, 0); send(7, 8, 1); wait_idle();
    check("R3 event count", ev_n, 6);
    chk_ev(0, 0, b, 0, 32, "R2 header");
    chk_ev(1, 1, b + 32'h100, 0, 40, "R2 first payload");
    chk_ev(2, 1, b + 32'h100, 40, 24, "R4 split head");
    chk_ev(3, 1, b + 32'h200, 0, 16, "R4 split tail");
    chk_ev(4, 1, b + 32'h200, 16, 8, "R3 append");
    chk_ev(5, 3, b + 32'h200, 3, 88, "R7 final");
  endtask

  task automatic t_gap();
    logic [AW-1:0] b = next_buf;
    ev_n = 0;
    send(10, 16, 0); send(12, 16, 0); send(13, 16, 1); wait_idle();
    check("R6 event count", ev_n, 7);
    chk_ev(0, 0, b, 0, 32, "R2 header");
    chk_ev(1, 1, b + 32'h100, 0, 16, "R2 payload");
    chk_ev(2, 2, b + 32'h100, 1, 16, "R5 closing completion");
    chk_ev(3, 0, b + 32'h200, 0, 32, "R6 new header");
    chk_ev(4, 1, b + 32'h300, 0, 16, "R6 new data buffer");
    chk_ev(5, 1, b + 32'h300, 16, 16, "R6 append after gap");
    chk_ev(6, 3, b + 32'h300, 2, 32, "R7 final");
  endtask

  task automatic t_exact_zero();
    logic [AW-1:0] b = next_buf;
    ev_n = 0;
    send(0, 64, 0); send(1, 0, 0); send(2, 1, 1); wait_idle();
    check("R10 event count", ev_n, 4);
    chk_ev(0, 0, b, 0, 32, "R2 header");
    chk_ev(1, 1, b + 32'h100, 0, 64, "R4 exact fill");
    chk_ev(2, 1, b + 32'h200, 0, 1, "R4 next buffer after full");
    chk_ev(3, 3, b + 32'h200, 3, 65, "R10 final totals");
  endtask

  task automatic t_wrap_gap_last();
    logic [AW-1:0] b = next_buf;
    ev_n = 0;
    send(65535, 8, 0); send(0, 8, 0); send(7, 8, 1); wait_idle();
    check("R3 wrap event count", ev_n, 7);
    chk_ev(1, 1, b + 32'h100, 0, 8, "R3 payload");
    chk_ev(2, 1, b + 32'h100, 8, 8, "R3 wrap in order");
    chk_ev(3, 2, b + 32'h100, 2, 16, "R5 close on last frame");
    chk_ev(4, 0, b + 32'h200, 0, 32, "R6 header");
    chk_ev(5, 1, b + 32'h300, 0, 8, "R6 payload");
    chk_ev(6, 3, b + 32'h300, 1, 8, "R7 final");
  endtask

  task automatic t_after_final();
    logic [AW-1:0] b = next_buf;
    ev_n = 0;
    send(8, 4, 1); wait_idle();
    check("R7 reopen event count", ev_n, 3);
    chk_ev(0, 0, b, 0, 32, "R7 new sequence header");
    chk_ev(2, 3, b + 32'h100, 1, 4, "R7 final");
  endtask

  task automatic t_stall();
    logic [AW-1:0] b = next_buf;
    ev_n = 0; fb_valid = 0; takes = 0;
    send(3, 10, 1);
    repeat (10) @(negedge clk);
    check("R8 ready held low", frm_ready, 0);
    check("R8 no writes while empty", ev_n, 0);
    check("R8 no take while empty", takes, 0);
    fb_valid = 1;
    wait_idle();
    check("R8 event count", ev_n, 3);
    chk_ev(0, 0, b, 0, 32, "R8 header after refill");
    chk_ev(1, 1, b + 32'h100, 0, 10, "R8 payload after refill");
  endtask

  task automatic t_long();
    logic [AW-1:0] b = next_buf;
    buf_bytes = 48; ev_n = 0;
    send(1, 150, 1); wait_idle();
    check("R4 long event count", ev_n, 6);
    chk_ev(1, 1, b + 32'h100, 0, 48, "R4 slice 1");
    chk_ev(2, 1, b + 32'h200, 0, 48, "R4 slice 2");
    chk_ev(3, 1, b + 32'h300, 0, 48, "R4 slice 3");
    chk_ev(4, 1, b + 32'h400, 0, 6, "R11 slice 4");
    chk_ev(5, 3, b + 32'h400, 1, 150, "R7 final");
    buf_bytes = 64;
  endtask

  task automatic t_busy();
    ev_n = 0;
    send(20, 100, 1);
    check("R9 ready low while placing", frm_ready, 0);
    wait_idle();
    check("R9 ready back", frm_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_in_order();
    t_gap();
    t_exact_zero();
    t_wrap_gap_last();
    t_after_final();
    t_stall();
    t_long();
    t_busy();
    check("R7 irq only with final completion", stray_irq, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule